// File: doc/BRIEF.md
# Streaming 3x3 Depthwise Convolver

This block applies a separate 3x3 kernel to each of several channel lanes of a pixel stream that arrives in raster order, one pixel position per accepted beat with every lane's sample side by side. Two chained row stores hold the two previous rows. Together with three columns of window registers per lane they present a full 3x3 neighbourhood as each pixel arrives. Each lane multiplies its window by its own nine stationary weights and sums the products at full precision. Left and right borders are always zero-padded. Top and bottom borders are padded only when the tile flags say the tile touches that edge of the feature map. Otherwise the first or last row of the tile is treated as overlap: it feeds its neighbours but produces no result of its own. With stride 2, only results centred on even rows and even columns of the tile are emitted.

A tile starts with a one-cycle `start` pulse that captures the row width, the row count, the stride, the two edge flags and all weights. The sequencer has four states. IDLE waits for `start` and moves to STREAM. STREAM accepts pixels whenever `in_valid` is high. After the last pixel of the last row it moves to FLUSH if the bottom flag is set, and to DRAIN if not. FLUSH feeds one internal row of zeros, one per cycle, and then moves to DRAIN. DRAIN lasts one cycle, so that the right-edge result of the final row can be emitted, and then returns to IDLE. Results leave with `out_valid` in raster order of their window centres.

Top module: `dw_line_conv`

## Requirements
- R1: While reset is asserted and afterwards, `out_valid` stays low until a tile has been started and enough pixels have been accepted to complete a window.
- R2: For a window centred on tile row r and column c, lane l outputs the sum over dr, dc in 0..2 of w[l][3*dr+dc] * x[r+dr-1][c+dc-1]. Here dr=0 is the upper row and dc=0 the left column. Columns outside 0..W-1 count as zero. Results are signed two's complement, 20 bits per lane, at `out_acc[l*20 +: 20]`.
- R3: Lane l uses only its own channel `in_pix[l*8 +: 8]` (signed) and its own weights `wgt_in[(l*9+t)*8 +: 8]` (signed, t=3*dr+dc). The lanes do not interact.
- R4: The row width is set at run time, from 2 to the maximum row length. Results do not depend on idle gaps (`in_valid` low) anywhere in the stream.
- R5: With the top flag set, the row above tile row 0 counts as zero and results centred on row 0 are produced. With it clear, row 0 produces no results.
- R6: With the bottom flag set, the block supplies a zero row below the last tile row and produces results centred on it. With it clear, the last row produces no results.
- R7: With stride 2 selected, only centres whose tile row and column are both even are emitted.
- R8: Exactly one result is emitted per eligible centre, in raster order. A centre at column c < W-1 appears one cycle after the pixel at column c+1 of the next row is accepted. A right-edge centre appears two cycles after the last pixel of the next row is accepted.
- R9: `in_valid` has no effect in IDLE, in the cycle of `start`, or during the internal zero row. No result appears and the later results are unchanged.
- R10: Configuration and weights are captured at `start`. Changing those inputs during a tile has no effect on its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a tile and captures configuration and weights (IDLE only) |
| cfg_width | input | 5 | Pixels per row, 2..16 |
| cfg_rows | input | 10 | Rows in the tile, at least 1 |
| cfg_stride2 | input | 1 | 1 selects stride 2, 0 selects stride 1 |
| cfg_top_edge | input | 1 | Tile touches the top of the map: zero row above |
| cfg_bot_edge | input | 1 | Tile touches the bottom of the map: zero row below |
| wgt_in | input | 576 | Nine signed 8-bit weights per lane |
| in_valid | input | 1 | Pixel beat valid |
| in_pix | input | 64 | Eight signed 8-bit channel samples |
| out_valid | output | 1 | Result valid |
| out_acc | output | 160 | Eight signed 20-bit sums |

## Verification
Tiles are swept over widths from the minimum to the maximum, over single-row and multi-row heights, and over all four edge-flag combinations in both strides. Each result's value, arrival cycle and total count is compared with sums computed in the bench. Lane-varying ramps separate a mixed-up tap, lane or row-store order from a correct one. Saturating patterns of all -128 pixels against -128 or +127 weights expose a narrow or unsigned accumulator. Streams with scattered idle gaps, junk beats driven while idle or during the zero row, and scrambled configuration inputs mid-tile show whether those inputs leak into the window.

// File: rtl/dwlc_pkg.sv
package dwlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_DRAIN  = 2'd3
    } seq_state_e;

    localparam int KDIM = 3;
    localparam int TAPS = KDIM * KDIM;
endpackage

// File: rtl/dw_row_fifo.sv
// One row store: read then overwrite at the same column, so it behaves as a
// queue whose length equals the run-time row width.
module dw_row_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16,
    parameter int AD    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AD-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/dw_tap_mac.sv
module dw_tap_mac
    import dwlc_pkg::*;
#(
    parameter int DW = 8,
    parameter int WW = 8,
    parameter int AW = 20
) (
    input  logic [TAPS*DW-1:0] win,
    input  logic [TAPS*WW-1:0] wts,
    output logic signed [AW-1:0] sum
);
    logic signed [DW+WW-1:0] prod;

    always_comb begin
        sum  = '0;
        prod = '0;
        for (int t = 0; t < TAPS; t++) begin
            prod = $signed(win[t*DW +: DW]) * $signed(wts[t*WW +: WW]);
            sum  = sum + AW'(prod);
        end
    end
endmodule

// File: rtl/dw_tile_seq.sv
module dw_tile_seq
    import dwlc_pkg::*;
#(
    parameter int CW = 5,
    parameter int RW = 10,
    parameter int AD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [CW-1:0] cfg_width,
    input  logic [RW-1:0] cfg_rows,
    input  logic          cfg_stride2,
    input  logic          cfg_top,
    input  logic          cfg_bot,
    output logic          load,
    output logic          take,
    output logic          flush_px,
    output logic [AD-1:0] rd_addr,
    output logic          col_first,
    output logic          mask_top,
    output logic          win_ok,
    output logic          pend_q,
    output logic          pend_ok_q
);
    seq_state_e state_q, state_d;

    logic [CW-1:0] w_q, col_q;
    logic [RW-1:0] h_q, row_q;
    logic          s2_q, top_q, bot_q;
    logic          last_col, row_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        take     = 1'b0;
        flush_px = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_STREAM;
                end
            end
            ST_STREAM: begin
                take = in_valid;
                if (in_valid && last_col && (row_q == h_q - 1'b1))
                    state_d = bot_q ? ST_FLUSH : ST_DRAIN;
            end
            ST_FLUSH: begin
                take     = 1'b1;
                flush_px = 1'b1;
                if (last_col) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign last_col  = (col_q == w_q - 1'b1);
    assign col_first = (col_q == '0);
    assign mask_top  = (row_q == RW'(1));
    assign rd_addr   = col_q[AD-1:0];

    // window centre is one row above the arriving pixel
    assign row_ok = (row_q != '0) && ((row_q != RW'(1)) || top_q) &&
                    ((row_q != h_q) || bot_q) && (!s2_q || row_q[0]);
    assign win_ok = take && !col_first && row_ok && (!s2_q || col_q[0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q       <= '0;
            h_q       <= '0;
            s2_q      <= 1'b0;
            top_q     <= 1'b0;
            bot_q     <= 1'b0;
            col_q     <= '0;
            row_q     <= '0;
            pend_q    <= 1'b0;
            pend_ok_q <= 1'b0;
        end else begin
            pend_q    <= take && last_col;
            pend_ok_q <= take && last_col && row_ok && (!s2_q || w_q[0]);
            if (load) begin
                w_q   <= cfg_width;
                h_q   <= cfg_rows;
                s2_q  <= cfg_stride2;
                top_q <= cfg_top;
                bot_q <= cfg_bot;
                col_q <= '0;
                row_q <= '0;
            end else if (take) begin
                if (last_col) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end

    p_col_in_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (col_q < w_q));
    p_flush_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> bot_q);
    p_drain_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> (state_q == ST_IDLE));
    p_pend_at_row_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (col_q == '0));
endmodule

// File: rtl/dw_line_conv.sv
module dw_line_conv
    import dwlc_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 8,
    parameter int WW    = 8,
    parameter int MAXW  = 16,
    parameter int RW    = 10,
    parameter int AW    = DW + WW + 4,
    parameter int CW    = $clog2(MAXW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CW-1:0]            cfg_width,
    input  logic [RW-1:0]            cfg_rows,
    input  logic                     cfg_stride2,
    input  logic                     cfg_top_edge,
    input  logic                     cfg_bot_edge,
    input  logic [LANES*TAPS*WW-1:0] wgt_in,
    input  logic                     in_valid,
    input  logic [LANES*DW-1:0]      in_pix,
    output logic                     out_valid,
    output logic [LANES*AW-1:0]      out_acc
);
    localparam int PW = LANES * DW;
    localparam int AD = $clog2(MAXW);

    logic          load, take, flush_px, col_first, mask_top;
    logic          win_ok, pend_q, pend_ok_q;
    logic [AD-1:0] rd_addr;
    logic [PW-1:0] pix_sel, mid_row, top_row;
    logic [LANES*TAPS*WW-1:0] wgt_q;

    dw_tile_seq #(.CW(CW), .RW(RW), .AD(AD)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .cfg_width(cfg_width), .cfg_rows(cfg_rows), .cfg_stride2(cfg_stride2),
        .cfg_top(cfg_top_edge), .cfg_bot(cfg_bot_edge),
        .load(load), .take(take), .flush_px(flush_px), .rd_addr(rd_addr),
        .col_first(col_first), .mask_top(mask_top), .win_ok(win_ok),
        .pend_q(pend_q), .pend_ok_q(pend_ok_q)
    );

    assign pix_sel = flush_px ? '0 : in_pix;

    dw_row_fifo #(.WIDTH(PW), .DEPTH(MAXW), .AD(AD)) u_row_near (
        .clk(clk), .wr_en(take), .addr(rd_addr),
        .wr_data(pix_sel), .rd_data(mid_row)
    );
    dw_row_fifo #(.WIDTH(PW), .DEPTH(MAXW), .AD(AD)) u_row_far (
        .clk(clk), .wr_en(take), .addr(rd_addr),
        .wr_data(mid_row), .rd_data(top_row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wgt_q <= '0;
        else if (load) wgt_q <= wgt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= pend_q ? pend_ok_q : win_ok;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW-1:0]         win_q [TAPS];
        logic [DW-1:0]         colv  [KDIM];
        logic [TAPS*DW-1:0]    nxt_flat, mac_flat;
        logic signed [AW-1:0]  lane_sum;
        logic [AW-1:0]         acc_q;

        always_comb begin
            colv[0] = mask_top ? '0 : top_row[l*DW +: DW];
            colv[1] = mid_row[l*DW +: DW];
            colv[2] = pix_sel[l*DW +: DW];
            for (int dr = 0; dr < KDIM; dr++) begin
                nxt_flat[(dr*KDIM+0)*DW +: DW] = col_first ? '0 : win_q[dr*KDIM+1];
                nxt_flat[(dr*KDIM+1)*DW +: DW] = col_first ? '0 : win_q[dr*KDIM+2];
                nxt_flat[(dr*KDIM+2)*DW +: DW] = colv[dr];
                // right-edge window: shift once more with a zero column
                mac_flat[(dr*KDIM+0)*DW +: DW] = pend_q ? win_q[dr*KDIM+1]
                                                        : nxt_flat[(dr*KDIM+0)*DW +: DW];
                mac_flat[(dr*KDIM+1)*DW +: DW] = pend_q ? win_q[dr*KDIM+2]
                                                        : nxt_flat[(dr*KDIM+1)*DW +: DW];
                mac_flat[(dr*KDIM+2)*DW +: DW] = pend_q ? '0
                                                        : nxt_flat[(dr*KDIM+2)*DW +: DW];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int t = 0; t < TAPS; t++) win_q[t] <= '0;
            end else if (take) begin
                for (int t = 0; t < TAPS; t++) win_q[t] <= nxt_flat[t*DW +: DW];
            end
        end

        dw_tap_mac #(.DW(DW), .WW(WW), .AW(AW)) u_mac (
            .win(mac_flat),
            .wts(wgt_q[l*TAPS*WW +: TAPS*WW]),
            .sum(lane_sum)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               acc_q <= '0;
            else if (take || pend_q)  acc_q <= lane_sum;
        end

        assign out_acc[l*AW +: AW] = acc_q;
    end

    p_out_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(take || pend_q));
    p_flush_no_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_px |-> take);
endmodule

// File: tb/dw_line_conv_bench.sv
module dw_line_conv_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int MAXW = 16;
    localparam int RW = 10;
    localparam int AW = 20;
    localparam int CW = 5;

    logic                   clk, rst_n, start, in_valid;
    logic [CW-1:0]          cfg_width;
    logic [RW-1:0]          cfg_rows;
    logic                   cfg_stride2, cfg_top_edge, cfg_bot_edge;
    logic [LANES*9*WW-1:0]  wgt_in, wgt_word;
    logic [LANES*DW-1:0]    in_pix;
    logic                   out_valid;
    logic [LANES*AW-1:0]    out_acc;

    dw_line_conv u_dw_line_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
        .cfg_rows(cfg_rows), .cfg_stride2(cfg_stride2),
        .cfg_top_edge(cfg_top_edge), .cfg_bot_edge(cfg_bot_edge),
        .wgt_in(wgt_in), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(out_valid), .out_acc(out_acc)
    );

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int px [0:12][0:15][0:7];
    int wt [0:7][0:8];
    int drv_c [0:12][0:15];
    int got_v [0:255][0:7];
    int got_c [0:255];
    int got_n = 0;
    int idle_outs = 0;
    bit idle_phase = 1'b1;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (out_valid) begin
            if (idle_phase) idle_outs++;
            else begin
                if (got_n < 256) begin
                    got_c[got_n] = cyc;
                    for (int l = 0; l < LANES; l++)
                        got_v[got_n][l] = int'($signed(out_acc[l*AW +: AW]));
                end
                got_n++;
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int expv(int rc, int cc, int l, int W, int H);
        int s = 0;
        for (int dr = 0; dr < 3; dr++)
            for (int dc = 0; dc < 3; dc++) begin
                int rr = rc + dr - 1;
                int c2 = cc + dc - 1;
                if (rr >= 0 && rr < H && c2 >= 0 && c2 < W)
                    s += wt[l][dr*3+dc] * px[rr][c2][l];
            end
        return s;
    endfunction

    task automatic run_tile(input int W, input int H, input bit top, input bit bot,
                            input bit s2, input bit gaps, input int mode, input int seed,
                            input string tag);
        int k;
        int n_last;
        int e_cyc;
        int bact;
        int bexp;
        bit bad;
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                for (int l = 0; l < LANES; l++)
                    px[r][c][l] = (mode == 0) ? ((r*37 + c*11 + l*53 + seed*17) % 256) - 128 : -128;
        for (int l = 0; l < LANES; l++)
            for (int t = 0; t < 9; t++) begin
                wt[l][t] = (mode == 0) ? ((l*29 + t*13 + seed*5) % 256) - 128 :
                           (mode == 1) ? -128 : 127;
                wgt_word[(l*9+t)*WW +: WW] = WW'(wt[l][t]);
            end
        // junk beats while idle (R9)
        idle_outs  = 0;
        idle_phase = 1'b1;
        repeat (3) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = {LANES{8'h5a}};
        end
        @(negedge clk);
        start        = 1'b1;
        in_valid     = 1'b1;
        cfg_width    = CW'(W);
        cfg_rows     = RW'(H);
        cfg_stride2  = s2;
        cfg_top_edge = top;
        cfg_bot_edge = bot;
        wgt_in       = wgt_word;
        got_n        = 0;
        @(negedge clk);
        start        = 1'b0;
        in_valid     = 1'b0;
        idle_phase   = 1'b0;
        // scramble captured inputs mid-tile (R10)
        cfg_width    = '1;
        cfg_rows     = '0;
        cfg_stride2  = ~s2;
        cfg_top_edge = ~top;
        cfg_bot_edge = ~bot;
        wgt_in       = ~wgt_word;
        check(idle_outs == 0, $sformatf("R9 %s outputs while idle", tag), idle_outs, 0);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                if (gaps && ((r*7 + c) % 3 == 0)) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                for (int l = 0; l < LANES; l++) in_pix[l*DW +: DW] = DW'(px[r][c][l]);
                drv_c[r][c] = cyc;
                @(negedge clk);
            end
        // junk during zero row and drain (R9)
        in_valid = 1'b1;
        in_pix   = {LANES{8'h7f}};
        repeat (W + 3) @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_last = drv_c[H-1][W-1];
        if (bot) for (int c = 0; c < W; c++) drv_c[H][c] = n_last + 1 + c;
        k = 0;
        for (int rc = 0; rc < H; rc++)
            for (int cc = 0; cc < W; cc++) begin
                if ((rc > 0 || top) && (rc < H-1 || bot) &&
                    (!s2 || ((rc % 2 == 0) && (cc % 2 == 0)))) begin
                    e_cyc = (cc < W-1) ? drv_c[rc+1][cc+1] + 1 : drv_c[rc+1][W-1] + 2;
                    if (k < got_n && k < 256) begin
                        check(got_c[k] == e_cyc,
                              $sformatf("R8 %s cycle of centre (%0d,%0d)", tag, rc, cc),
                              got_c[k], e_cyc);
                        bad = 1'b0; bact = 0; bexp = 0;
                        for (int l = 0; l < LANES; l++)
                            if (!bad && got_v[k][l] != expv(rc, cc, l, W, H)) begin
                                bad  = 1'b1;
                                bact = got_v[k][l];
                                bexp = expv(rc, cc, l, W, H);
                            end
                        check(!bad, $sformatf("%s R2 R3 R10 sum at (%0d,%0d)", tag, rc, cc),
                              bact, bexp);
                    end
                    k++;
                end
            end
        check(got_n == k, $sformatf("%s R8 result count W=%0d H=%0d", tag, W, H), got_n, k);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_pix = '0;
        cfg_width = '0; cfg_rows = '0; cfg_stride2 = 1'b0;
        cfg_top_edge = 1'b0; cfg_bot_edge = 1'b0; wgt_in = '0; wgt_word = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        run_tile(5, 4, 1, 1, 0, 0, 0, 1, "R2");
        run_tile(5, 4, 1, 1, 0, 0, 1, 2, "R2");
        run_tile(6, 3, 1, 1, 0, 0, 2, 3, "R2");
        run_tile(4, 5, 1, 1, 0, 0, 0, 4, "R3");
        run_tile(2, 3, 1, 1, 0, 0, 0, 5, "R4");
        run_tile(16, 3, 1, 1, 0, 1, 0, 6, "R4");
        run_tile(3, 4, 1, 1, 0, 1, 0, 7, "R4");
        run_tile(4, 5, 0, 0, 0, 0, 0, 8, "R5");
        run_tile(4, 5, 1, 0, 0, 1, 0, 9, "R5");
        run_tile(4, 5, 0, 1, 0, 0, 0, 10, "R6");
        run_tile(5, 1, 1, 1, 0, 0, 0, 11, "R6");
        run_tile(5, 1, 0, 1, 0, 0, 0, 12, "R6");
        run_tile(5, 5, 1, 1, 1, 0, 0, 13, "R7");
        run_tile(6, 6, 1, 1, 1, 0, 0, 14, "R7");
        run_tile(5, 6, 0, 0, 1, 1, 0, 15, "R7");
        run_tile(7, 5, 0, 1, 1, 1, 0, 16, "R7");
        run_tile(16, 12, 1, 1, 0, 1, 0, 17, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule